// File: doc/BRIEF.md
# Serial Control Port with Open-Drain Port Outputs

This block is a three-wire synchronous serial slave that loads a small set of control registers and drives a handful of port pins from them. A host raises the chip-enable line, clocks a control word in on the data-in line, and lowers chip-enable to make that word take effect. In the same transfer, a readback word is shifted out on the data-out line. A three-bit select field chosen in an earlier write decides what that readback word contains.

The registers drive four dedicated output ports and two dual-use pins. Every pin is modelled as a drive-low enable: 1 pulls the pin low, and 0 releases it to high impedance. Each dual-use pin has its own direction bit. When a dual-use pin is an input, its sampled level is reported in the readback. Port 0 can be switched to an 8 Hz time-base square wave. A 12-bit divider word is passed straight through to neighbouring blocks.

All serial inputs and the pin inputs are synchronised into the system clock domain. The serial clock must therefore be slow compared with the system clock, with each of its phases lasting at least four system clocks.

Top module: `serctl_port`

## Requirements
- R1: After reset, all `port_drive_low` bits are 0, both `io_drive_low` bits are 0 (both dual pins are inputs), `div_word` is 0, `sdo` is 0 and the readback select is 0.
- R2: While `ce` is high, `sdi` is sampled on each rising `sclk`. The frame is 24 bits and is sent bit 23 first. Bits [3:0] are the port data, [5:4] the direction bits (bit 4 for dual pin 0; 1 = output), [7:6] the dual-pin data, [8] the time-base enable, [11:9] the readback select and [23:12] the divider word. The frame takes effect after `ce` falls.
- R3: A port data bit of 1 drives its `port_drive_low` bit to 1, and a bit of 0 releases it.
- R4: A dual pin set as an output has its `io_drive_low` bit equal to its data bit. A dual pin set as an input is released whatever its data bit is.
- R5: A frame of fewer than 24 clocks is discarded and leaves every output unchanged. A frame of more than 24 clocks commits its last 24 bits.
- R6: `div_word` equals the divider field of the last committed frame.
- R7: When `ce` rises, an 8-bit readback word is loaded and shifted out MSB first on `sdo`. It advances one bit after each falling `sclk`. The committed select picks the word: 0 gives {6'b0, pin levels}, where bit 1 is dual pin 1 and a pin set as output reads 0; 1 gives {4'b0, port data}; 2 gives divider[7:0]; 3 gives {4'b0, divider[11:8]}; any other value gives 0.
- R8: `sdo` is 0 while `ce` is low.
- R9: With the time-base enable set, `port_drive_low[0]` alternates every CLK_HZ/(2*TB_HZ) clocks and ignores port data bit 0. Ports 3..1 keep following their data bits.
- R10: Apart from the time base on port 0, `port_drive_low` and `io_drive_low` change only when a frame is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Serial chip enable, active high |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial readback data to host |
| io_pin_in | input | 2 | Sampled levels of the dual-use pins |
| port_drive_low | output | 4 | Pull-low enables for dedicated ports |
| io_drive_low | output | 2 | Pull-low enables for dual-use pins |
| div_word | output | 12 | Divider setting passed to other blocks |

## Verification
A corrupted control register shows on the pin enables, on `div_word` or in the readback within about five system clocks after `ce` falls. A fault in the receive shifter or the bit counter shows up as a wrong field position or as a short frame that is wrongly accepted. Such faults are seen in the same transfer that caused them. A readback shifter that is out of step with the falling edges misplaces bits from the first bit onward. A time-base fault shows as a wrong toggle count over a window of a few periods.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    RB_PINS   = 3'd0,
    RB_PORTS  = 3'd1,
    RB_DIV_LO = 3'd2,
    RB_DIV_HI = 3'd3
  } rb_sel_e;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/serctl_rx.sv
module serctl_rx #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               sample,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame,
  output logic               full
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= '0;
      cnt   <= '0;
    end else if (start) begin
      cnt   <= '0;
    end else if (sample) begin
      frame <= {frame[FRAME_W-2:0], bit_in};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_MAX);
endmodule

// File: rtl/serctl_tx.sv
module serctl_tx #(
  parameter int RD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [RD_W-1:0] load_val,
  input  logic            shift,
  input  logic            clear,
  output logic            sdo
);
  logic [RD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst || clear) sreg <= '0;
    else if (load)    sreg <= load_val;
    else if (shift)   sreg <= {sreg[RD_W-2:0], 1'b0};
  end

  assign sdo = sreg[RD_W-1];
endmodule

// File: rtl/serctl_timebase.sv
module serctl_timebase #(
  parameter int HALF = 100
) (
  input  logic clk,
  input  logic rst,
  output logic level
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      level <= 1'b1;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      level <= ~level;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int N_PORT      = 4,
  parameter int N_IO        = 2,
  parameter int DIV_W       = 12,
  parameter int RD_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_HZ      = 50_000_000,
  parameter int TB_HZ       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  input  logic [N_IO-1:0]   io_pin_in,
  output logic [N_PORT-1:0] port_drive_low,
  output logic [N_IO-1:0]   io_drive_low,
  output logic [DIV_W-1:0]  div_word
);
  localparam int FRAME_W = N_PORT + 2*N_IO + 1 + SEL_W + DIV_W;
  localparam int O_DIR   = N_PORT;
  localparam int O_DAT   = O_DIR + N_IO;
  localparam int O_TB    = O_DAT + N_IO;
  localparam int O_SEL   = O_TB + 1;
  localparam int O_DIV   = O_SEL + SEL_W;
  localparam int TB_HALF = CLK_HZ / (2 * TB_HZ);

  // synchronisers
  logic [N_IO+2:0] sync_q;
  logic ce_s, sclk_s, sdi_s;
  logic [N_IO-1:0] io_s;

  serctl_sync #(.W(N_IO+3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({ce, sclk, sdi, io_pin_in}),
    .q(sync_q)
  );
  assign {ce_s, sclk_s, sdi_s, io_s} = sync_q;

  // edge detection
  logic ce_d, sclk_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      ce_d   <= ce_s;
      sclk_d <= sclk_s;
    end
  end

  logic ce_rise, ce_fall, sclk_rise, sclk_fall;
  assign ce_rise   = ce_s & ~ce_d;
  assign ce_fall   = ~ce_s & ce_d;
  assign sclk_rise = ce_s & ~ce_rise & sclk_s & ~sclk_d;
  assign sclk_fall = ce_s & ~ce_rise & ~sclk_s & sclk_d;

  // receive path
  logic [FRAME_W-1:0] frame;
  logic frame_full;

  serctl_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst(rst),
    .start(ce_rise), .sample(sclk_rise), .bit_in(sdi_s),
    .frame(frame), .full(frame_full)
  );

  logic commit;
  assign commit = ce_fall & frame_full;

  // control registers
  logic [N_PORT-1:0] port_q;
  logic [N_IO-1:0]   dir_q;
  logic              tb_en_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DIV_W-1:0]  div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q  <= '0;
      dir_q   <= '0;
      tb_en_q <= 1'b0;
      sel_q   <= '0;
      div_q   <= '0;
    end else if (commit) begin
      port_q  <= frame[0 +: N_PORT];
      dir_q   <= frame[O_DIR +: N_IO];
      tb_en_q <= frame[O_TB];
      sel_q   <= frame[O_SEL +: SEL_W];
      div_q   <= frame[O_DIV +: DIV_W];
    end
  end

  // time base and pin outputs
  logic tb_level;
  serctl_timebase #(.HALF(TB_HALF)) u_tb (
    .clk(clk), .rst(rst), .level(tb_level)
  );

  logic [N_PORT-1:0] port_nxt;
  logic              tb_nxt;
  logic [N_PORT-1:0] port_out_q;
  logic [N_IO-1:0]   io_out_q;

  assign port_nxt = commit ? frame[0 +: N_PORT] : port_q;
  assign tb_nxt   = commit ? frame[O_TB] : tb_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_out_q <= '0;
      io_out_q   <= '0;
    end else begin
      port_out_q <= {port_nxt[N_PORT-1:1], tb_nxt ? ~tb_level : port_nxt[0]};
      if (commit)
        io_out_q <= frame[O_DIR +: N_IO] & frame[O_DAT +: N_IO];
    end
  end

  assign port_drive_low = port_out_q;
  assign io_drive_low   = io_out_q;
  assign div_word       = div_q;

  // readback path
  logic [RD_W-1:0] rb_word;
  always_comb begin
    case (rb_sel_e'(sel_q))
      RB_PINS:   rb_word = RD_W'(io_s & ~dir_q);
      RB_PORTS:  rb_word = RD_W'(port_q);
      RB_DIV_LO: rb_word = div_q[RD_W-1:0];
      RB_DIV_HI: rb_word = RD_W'(div_q >> RD_W);
      default:   rb_word = '0;
    endcase
  end

  serctl_tx #(.RD_W(RD_W)) u_tx (
    .clk(clk), .rst(rst),
    .load(ce_rise), .load_val(rb_word),
    .shift(sclk_fall), .clear(ce_fall),
    .sdo(sdo)
  );
endmodule

// File: rtl/serctl_port_chk.sv
module serctl_port_chk #(
  parameter int N_PORT = 4,
  parameter int N_IO   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              commit,
  input logic              ce_s,
  input logic              ce_rise,
  input logic              sclk_fall,
  input logic              sdo,
  input logic [N_PORT-1:0] port_drive_low,
  input logic [N_IO-1:0]   io_drive_low
);
  // R1: reset releases every pin and clears readback
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (port_drive_low == '0 && io_drive_low == '0 && sdo == 1'b0));

  // R10: dual pins hold between commits
  assert_io_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(io_drive_low));

  // R10: ports above port 0 hold between commits
  assert_port_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(port_drive_low[N_PORT-1:1]));

  // R8: idle data-out while chip enable is low
  assert_sdo_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> (sdo == 1'b0));

  // R7: readback advances only on falling shift clock
  assert_sdo_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (ce_s && !ce_rise && !sclk_fall) |=> $stable(sdo));
endmodule

bind serctl_port serctl_port_chk #(.N_PORT(N_PORT), .N_IO(N_IO)) u_chk (
  .clk(clk), .rst(rst), .commit(commit), .ce_s(ce_s), .ce_rise(ce_rise),
  .sclk_fall(sclk_fall), .sdo(sdo),
  .port_drive_low(port_drive_low), .io_drive_low(io_drive_low)
);

// File: tb/serctl_port_tb.sv
module serctl_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [1:0]  io_pin_in = 2'b00;
  logic [3:0]  port_drive_low;
  logic [1:0]  io_drive_low;
  logic [11:0] div_word;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serctl_port #(.CLK_HZ(1600), .TB_HZ(8)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .io_pin_in(io_pin_in), .port_drive_low(port_drive_low),
    .io_drive_low(io_drive_low), .div_word(div_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [3:0] prt, input logic [1:0] dir,
                                     input logic [1:0] dat, input logic tb,
                                     input logic [2:0] sel, input logic [11:0] dv);
    return {dv, sel, tb, dat, dir, prt};
  endfunction

  task automatic xfer(input logic [31:0] w, input int nbits, output logic [7:0] rd);
    rd = '0;
    @(negedge clk); ce = 1'b1;
    repeat (10) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[nbits-1-i];
      repeat (4) @(negedge clk);
      if (i < 8) rd[7-i] = sdo;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    ce = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ports", 32'(port_drive_low), 0);
    check("R1 dual", 32'(io_drive_low), 0);
    check("R1 div", 32'(div_word), 0);
    check("R8 sdo idle", 32'(sdo), 0);
  endtask

  task automatic t_write;
    logic [7:0] rd;
    xfer(32'(mk(4'b1010, 2'b01, 2'b11, 1'b0, 3'd1, 12'hA5C)), 24, rd);
    check("R7 sel0 after reset", 32'(rd), 0);
    check("R2 R3 ports", 32'(port_drive_low), 32'h0A);
    check("R4 dual out/in", 32'(io_drive_low), 32'h1);
    check("R6 div", 32'(div_word), 32'hA5C);
    check("R8 sdo idle after frame", 32'(sdo), 0);
  endtask

  task automatic t_readback;
    logic [7:0] rd;
    io_pin_in = 2'b11;
    xfer(32'(mk(4'b1010, 2'b01, 2'b10, 1'b0, 3'd0, 12'hA5C)), 24, rd);
    check("R7 sel1 ports", 32'(rd), 32'h0A);
    check("R4 dual data0 low released", 32'(io_drive_low), 32'h0);
    xfer(32'(mk(4'b1010, 2'b00, 2'b11, 1'b0, 3'd2, 12'hA5C)), 24, rd);
    check("R7 sel0 pins dir01", 32'(rd), 32'h2);
    check("R4 inputs released", 32'(io_drive_low), 32'h0);
    xfer(32'(mk(4'b1010, 2'b10, 2'b10, 1'b0, 3'd3, 12'hA5C)), 24, rd);
    check("R7 sel2 div lo", 32'(rd), 32'h5C);
    check("R4 pin1 output low", 32'(io_drive_low), 32'h2);
    xfer(32'(mk(4'b1010, 2'b10, 2'b10, 1'b0, 3'd6, 12'hA5C)), 24, rd);
    check("R7 sel3 div hi", 32'(rd), 32'h0A);
    io_pin_in = 2'b01;
    xfer(32'(mk(4'b1010, 2'b00, 2'b00, 1'b0, 3'd0, 12'hA5C)), 24, rd);
    check("R7 sel6 zero", 32'(rd), 32'h0);
    xfer(32'(mk(4'b1010, 2'b00, 2'b00, 1'b0, 3'd0, 12'hA5C)), 24, rd);
    check("R7 sel0 pins dir00", 32'(rd), 32'h1);
  endtask

  task automatic t_length;
    logic [7:0] rd;
    xfer(32'h3FF, 10, rd);
    check("R5 short ports", 32'(port_drive_low), 32'h0A);
    check("R5 short div", 32'(div_word), 32'hA5C);
    xfer({2'b00, 6'b111111, mk(4'b0101, 2'b11, 2'b01, 1'b0, 3'd1, 12'h3C7)}, 30, rd);
    check("R5 long ports", 32'(port_drive_low), 32'h05);
    check("R5 long dual", 32'(io_drive_low), 32'h1);
    check("R5 R6 long div", 32'(div_word), 32'h3C7);
  endtask

  task automatic t_timebase;
    logic [7:0] rd;
    logic prev;
    int tog;
    xfer(32'(mk(4'b1100, 2'b00, 2'b00, 1'b1, 3'd1, 12'h001)), 24, rd);
    prev = port_drive_low[0];
    tog = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (port_drive_low[0] != prev) tog++;
      prev = port_drive_low[0];
      if (i == 1000) check("R9 upper ports", 32'(port_drive_low[3:1]), 32'h6);
    end
    check("R9 toggles in range", 32'(tog >= 19 && tog <= 21), 1);
    xfer(32'(mk(4'b0001, 2'b00, 2'b00, 1'b0, 3'd1, 12'h001)), 24, rd);
    tog = 0;
    prev = port_drive_low[0];
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (port_drive_low[0] != prev) tog++;
      prev = port_drive_low[0];
    end
    check("R9 off no toggles", 32'(tog), 0);
    check("R3 port0 from data", 32'(port_drive_low), 32'h1);
  endtask

  initial begin
    t_reset();
    t_write();
    t_readback();
    t_length();
    t_timebase();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule